// File: doc/BRIEF.md
# Extended Capability List Walker

This block searches the chain of extended capability headers that sits in the upper part of a 4 KB configuration space, starting at byte offset 0x100. It reads one 32-bit header at a time from a synchronous memory with one cycle of read latency. It follows each header's 12-bit link field until it finds a requested capability ID or reaches the end of the chain. A search reports the offset where the match sits and the offset of the header before it. Searching for ID 0 reports the last header of the chain.

The same engine appends a new capability. A request names an offset, a region size, an ID and a version. If the offset is 0x100, the block rewrites the head header and keeps the link that was already stored there. Otherwise it locates the tail, rewrites only the tail's link field, and then writes the new header with an empty link. Bad region requests, out-of-range or misaligned links, and chains that never end are reported on an error flag. None of them stops the block.

Top module: `ecap_walker`

## Requirements
- R1: A header word holds the ID in bits [15:0], the version in bits [19:16] and the byte offset of the next header in bits [31:20]. The walk always begins by reading byte address 0x100. `mem_addr` is a byte address, and only one header is read per hop.
- R2: If the word read at 0x100 is all zeros, a search completes with `res_off` = 0, `res_prev` = 0 and no error, whatever ID was requested.
- R3: A search that finds a header whose ID field equals `cmd_id` completes with `res_off` set to that header's offset. `res_prev` is set to the offset of the header read just before it, or 0 when the match is at 0x100.
- R4: A search that reaches a header with link field 0 without a match completes with `res_off` = 0 and `res_prev` = that last header's offset. Searching for ID 0 therefore returns the tail.
- R5: The walk stops with `err` = 1 if it must follow a link that is not a multiple of 4, is below 0x100, or is above 0xFF8. A link of exactly 0xFF8 is followed.
- R6: If the 1024th header read still links onward, the walk stops with `err` = 1. This guards against a cyclic chain.
- R7: An append at offset 0x100 reads the head word and writes it back with the new ID and version in bits [19:0] and the old bits [31:20] unchanged. It reports `res_off` = 0x100 and `res_prev` = 0.
- R8: An append elsewhere finds the tail and rewrites the tail header with only bits [31:20] replaced by the new offset. It then writes {12'h000, version, ID} at the new offset, and reports `res_off` = new offset and `res_prev` = tail offset.
- R9: An append request is refused with `err` = 1 and no memory write if any of these holds: size < 8, offset < 0x100, offset not a multiple of 4, or offset + size ≥ 0x1000. In that case `busy` never rises and `done` follows in the next cycle. Offset + size = 0xFFC is accepted.
- R10: An append at an offset other than 0x100 fails with `err` = 1 and no write in two cases: the chain is empty, or the tail search meets a header whose ID field is 0.
- R11: `busy` is high for exactly 2 cycles per header read. A head append adds 1 cycle and any other successful append adds 2 cycles. `done` is a one-cycle pulse in the cycle after `busy` falls. `start` is ignored while `busy` is high.
- R12: After reset `busy`, `done`, `err`, `mem_rd_en` and `mem_wr_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Starts an operation when idle |
| cmd_append | input | 1 | 0 = search, 1 = append |
| cmd_id | input | 16 | ID searched for, or ID of the new header |
| cmd_ver | input | 4 | Version of the new header |
| cmd_off | input | 12 | Byte offset of the new header |
| cmd_size | input | 13 | Byte size of the new capability region |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last operation failed (valid from done) |
| res_off | output | 12 | Match offset or appended offset |
| res_prev | output | 12 | Predecessor or tail offset |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | 12 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the strobe |

## Verification
Searches run against four kinds of chain.

- **Empty chain.** Tells the zero-header rule apart from a plain mismatch.
- **Three-entry chain.** Finding a match at the head, in the middle and at the tail tells the predecessor tracking apart from the result offset.
- **Broken chains.** Links of 0x302, 0x080 and 0xFFC are each flagged, and a link of 0xFF8 is followed. This separates each bounds comparison from its neighbour.
- **Two-node cycle.** Exercises the hop limit at its exact count.

Appends are tried on an empty chain, at the head of a live chain, after the tail, and at region boundaries on both sides of the limit. After every operation the whole memory is compared with a reference image, so any write that touches a wrong field or a wrong address is caught.

// File: rtl/ecap_pkg.sv
`timescale 1ns/1ps
// Shared widths and types for the extended capability list walker.
// Assumes a 4 KB configuration space addressed in bytes.
package ecap_pkg;
    localparam int OFF_W = 12;
    localparam int ID_W  = 16;
    localparam int VER_W = 4;
    localparam int HDR_W = OFF_W + VER_W + ID_W;
    localparam int LOW_W = VER_W + ID_W;

    typedef struct packed {
        logic [OFF_W-1:0] nxt;
        logic [VER_W-1:0] ver;
        logic [ID_W-1:0]  id;
    } ecap_hdr_t;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_REQ   = 3'd1,
        S_EVAL  = 3'd2,
        S_LINK  = 3'd3,
        S_PLACE = 3'd4
    } walk_state_e;
endpackage

// File: rtl/ecap_bounds.sv
`timescale 1ns/1ps
// Offset legality check. REGION=0 checks a link pointer: aligned, at or
// above the base, and leaving room for a full header (offset + 8 within
// the space). REGION=1 checks a new capability region: aligned, at or
// above the base, at least 8 bytes long and ending below the space size.
// Purely combinational.
module ecap_bounds
    import ecap_pkg::*;
#(
    parameter int BASE_OFF  = 256,
    parameter int CFG_BYTES = 4096,
    parameter int SIZE_W    = 13,
    parameter bit REGION    = 1'b0
) (
    input  logic [OFF_W-1:0]  off,
    input  logic [SIZE_W-1:0] size,
    output logic              ok
);
    localparam int SUM_W = SIZE_W + 1;

    logic [SUM_W-1:0] span;
    logic             base_ok;

    // Common part: alignment, lower bound and minimum size.
    always_comb begin
        span    = SUM_W'(off) + SUM_W'(size);
        base_ok = (off[1:0] == 2'b00) && (off >= OFF_W'(BASE_OFF)) &&
                  (size >= SIZE_W'(8));
    end

    generate
        if (REGION) begin : g_region
            // Region must end strictly below the space size.
            assign ok = base_ok && (span < SUM_W'(CFG_BYTES));
        end else begin : g_pointer
            // Header at the pointer must fit inside the space.
            assign ok = base_ok && (span <= SUM_W'(CFG_BYTES));
        end
    endgenerate
endmodule

// File: rtl/ecap_hop_guard.sv
`timescale 1ns/1ps
// Counts links followed during one walk and flags the last permitted read.
// Assumes clr and inc are never high together.
module ecap_hop_guard #(
    parameter int MAX_HOPS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CNT_W = $clog2(MAX_HOPS + 1);

    logic [CNT_W-1:0] cnt;

    // Link counter, cleared at the start of every operation.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (inc)      cnt <= cnt + CNT_W'(1);
    end

    // High while the read in flight is the MAX_HOPS-th of this walk.
    assign last = (cnt == CNT_W'(MAX_HOPS - 1));

    AST_HOPS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(MAX_HOPS)); // R6
    AST_NO_INC_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> !inc); // R6
endmodule

// File: rtl/ecap_hdr_merge.sv
`timescale 1ns/1ps
// Builds the two header words an append writes: the tail header with only
// its link field replaced, and the fresh header for the new capability.
// Purely combinational.
module ecap_hdr_merge
    import ecap_pkg::*;
(
    input  logic [LOW_W-1:0] keep_low,
    input  logic [OFF_W-1:0] link_off,
    input  logic [ID_W-1:0]  new_id,
    input  logic [VER_W-1:0] new_ver,
    input  logic [OFF_W-1:0] new_nxt,
    output logic [HDR_W-1:0] relinked,
    output logic [HDR_W-1:0] fresh
);
    ecap_hdr_t fresh_s;

    // Assemble the two output words.
    always_comb begin
        relinked      = {link_off, keep_low};
        fresh_s.nxt   = new_nxt;
        fresh_s.ver   = new_ver;
        fresh_s.id    = new_id;
        fresh         = fresh_s;
    end
endmodule

// File: rtl/ecap_walker.sv
`timescale 1ns/1ps
// Extended capability list walker. Searches the header chain rooted at
// BASE_OFF for an ID (ID 0 finds the tail), or appends a new header.
// Assumes a synchronous memory with one cycle of read latency and byte
// addressing of 32-bit words. Each hop is a request cycle and an
// evaluate cycle.
module ecap_walker
    import ecap_pkg::*;
#(
    parameter int BASE_OFF  = 256,
    parameter int CFG_BYTES = 4096,
    parameter int MAX_HOPS  = 1024,
    parameter int SIZE_W    = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cmd_append,
    input  logic [ID_W-1:0]   cmd_id,
    input  logic [VER_W-1:0]  cmd_ver,
    input  logic [OFF_W-1:0]  cmd_off,
    input  logic [SIZE_W-1:0] cmd_size,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [OFF_W-1:0]  res_off,
    output logic [OFF_W-1:0]  res_prev,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [OFF_W-1:0]  mem_addr,
    output logic [HDR_W-1:0]  mem_wdata,
    input  logic [HDR_W-1:0]  mem_rdata
);
    localparam int LAST_OFF = CFG_BYTES - 8;

    walk_state_e      state;
    logic             app_q, base_q, first_q, done_q, err_q;
    logic [OFF_W-1:0] cur_q, prv_q, off_q, place_nxt_q, res_off_q, res_prev_q;
    logic [ID_W-1:0]  id_q, key_q;
    logic [VER_W-1:0] ver_q;
    logic [LOW_W-1:0] keep_q;

    ecap_hdr_t        rh;
    logic             empty_w, hit_w, end_w, ptr_ok, region_ok, hop_last;
    logic             fin, fin_err, follow, go_link, go_place;
    logic [OFF_W-1:0] fin_off, fin_prev;
    logic [HDR_W-1:0] relinked, fresh;
    logic             accept;

    assign rh      = ecap_hdr_t'(mem_rdata);
    assign empty_w = first_q && (mem_rdata == '0);
    assign hit_w   = (rh.id == key_q);
    assign end_w   = (rh.nxt == '0);
    assign accept  = (state == S_IDLE) && start;

    ecap_bounds #(.BASE_OFF(BASE_OFF), .CFG_BYTES(CFG_BYTES),
                  .SIZE_W(SIZE_W), .REGION(1'b0)) u_link_chk (
        .off(rh.nxt), .size(SIZE_W'(8)), .ok(ptr_ok));

    ecap_bounds #(.BASE_OFF(BASE_OFF), .CFG_BYTES(CFG_BYTES),
                  .SIZE_W(SIZE_W), .REGION(1'b1)) u_region_chk (
        .off(cmd_off), .size(cmd_size), .ok(region_ok));

    ecap_hop_guard #(.MAX_HOPS(MAX_HOPS)) u_hops (
        .clk(clk), .rst_n(rst_n), .clr(accept), .inc(follow), .last(hop_last));

    ecap_hdr_merge u_merge (
        .keep_low(keep_q), .link_off(off_q), .new_id(id_q), .new_ver(ver_q),
        .new_nxt(place_nxt_q), .relinked(relinked), .fresh(fresh));

    // Decide what the header just returned by memory means for the walk.
    always_comb begin
        fin = 1'b0; fin_err = 1'b0; follow = 1'b0;
        go_link = 1'b0; go_place = 1'b0;
        fin_off = '0; fin_prev = '0;
        if (state == S_EVAL) begin
            if (!app_q) begin
                if (empty_w) begin
                    fin = 1'b1;
                end else if (hit_w) begin
                    fin = 1'b1; fin_off = cur_q; fin_prev = prv_q;
                end else if (end_w) begin
                    fin = 1'b1; fin_prev = cur_q;
                end else if (!ptr_ok || hop_last) begin
                    fin = 1'b1; fin_err = 1'b1;
                end else begin
                    follow = 1'b1;
                end
            end else if (base_q) begin
                go_place = 1'b1;
            end else begin
                if (empty_w || hit_w) begin
                    fin = 1'b1; fin_err = 1'b1;
                end else if (end_w) begin
                    go_link = 1'b1;
                end else if (!ptr_ok || hop_last) begin
                    fin = 1'b1; fin_err = 1'b1;
                end else begin
                    follow = 1'b1;
                end
            end
        end
    end

    // Sequencer: command capture, hop stepping, write-back and results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            app_q       <= 1'b0;
            base_q      <= 1'b0;
            first_q     <= 1'b0;
            done_q      <= 1'b0;
            err_q       <= 1'b0;
            cur_q       <= '0;
            prv_q       <= '0;
            off_q       <= '0;
            place_nxt_q <= '0;
            res_off_q   <= '0;
            res_prev_q  <= '0;
            id_q        <= '0;
            key_q       <= '0;
            ver_q       <= '0;
            keep_q      <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        err_q      <= 1'b0;
                        res_off_q  <= '0;
                        res_prev_q <= '0;
                        if (cmd_append && !region_ok) begin
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                        end else begin
                            app_q   <= cmd_append;
                            base_q  <= (cmd_off == OFF_W'(BASE_OFF));
                            key_q   <= cmd_append ? '0 : cmd_id;
                            id_q    <= cmd_id;
                            ver_q   <= cmd_ver;
                            off_q   <= cmd_off;
                            cur_q   <= OFF_W'(BASE_OFF);
                            prv_q   <= '0;
                            first_q <= 1'b1;
                            state   <= S_REQ;
                        end
                    end
                end
                S_REQ: state <= S_EVAL;
                S_EVAL: begin
                    if (fin) begin
                        done_q     <= 1'b1;
                        err_q      <= fin_err;
                        res_off_q  <= fin_off;
                        res_prev_q <= fin_prev;
                        state      <= S_IDLE;
                    end else if (follow) begin
                        prv_q   <= cur_q;
                        cur_q   <= rh.nxt;
                        first_q <= 1'b0;
                        state   <= S_REQ;
                    end else if (go_link) begin
                        keep_q      <= {rh.ver, rh.id};
                        prv_q       <= cur_q;
                        place_nxt_q <= '0;
                        state       <= S_LINK;
                    end else if (go_place) begin
                        place_nxt_q <= rh.nxt;
                        state       <= S_PLACE;
                    end
                end
                S_LINK: state <= S_PLACE;
                S_PLACE: begin
                    done_q     <= 1'b1;
                    res_off_q  <= off_q;
                    res_prev_q <= base_q ? '0 : prv_q;
                    state      <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Memory port steering by state.
    always_comb begin
        mem_rd_en = (state == S_REQ);
        mem_wr_en = (state == S_LINK) || (state == S_PLACE);
        case (state)
            S_REQ:   begin mem_addr = cur_q; mem_wdata = '0;       end
            S_LINK:  begin mem_addr = prv_q; mem_wdata = relinked; end
            S_PLACE: begin mem_addr = off_q; mem_wdata = fresh;    end
            default: begin mem_addr = '0;    mem_wdata = '0;       end
        endcase
    end

    assign busy     = (state != S_IDLE);
    assign done     = done_q;
    assign err      = err_q;
    assign res_off  = res_off_q;
    assign res_prev = res_prev_q;

    AST_RD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (mem_addr[1:0] == 2'b00 && mem_addr >= OFF_W'(BASE_OFF)
                       && mem_addr <= OFF_W'(LAST_OFF))); // R5
    AST_WR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (mem_addr[1:0] == 2'b00 &&
                       mem_addr >= OFF_W'(BASE_OFF))); // R8
    AST_WR_ONLY_APPEND: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> app_q); // R8
    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en)); // R1
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done || $past(start))); // R11
    AST_LINK_THEN_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LINK) |=> (state == S_PLACE)); // R8
endmodule

// File: tb/ecap_walker_bench.sv
`timescale 1ns/1ps
module ecap_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cmd_append = 1'b0;
    logic [15:0] cmd_id = '0;
    logic [3:0]  cmd_ver = '0;
    logic [11:0] cmd_off = '0;
    logic [12:0] cmd_size = '0;
    logic        busy, done, err, mem_rd_en, mem_wr_en;
    logic [11:0] res_off, res_prev, mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;

    logic [31:0] dmem [1024];
    logic [31:0] rmem [1024];
    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    ecap_walker u_ecap_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_append(cmd_append),
        .cmd_id(cmd_id), .cmd_ver(cmd_ver), .cmd_off(cmd_off),
        .cmd_size(cmd_size), .busy(busy), .done(done), .err(err),
        .res_off(res_off), .res_prev(res_prev), .mem_rd_en(mem_rd_en),
        .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata));

    // Bench-side config memory, one cycle read latency.
    always @(posedge clk) begin
        if (mem_wr_en) dmem[mem_addr[11:2]] <= mem_wdata;
        if (mem_rd_en) mem_rdata <= dmem[mem_addr[11:2]];
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, act=%0d exp<190000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, expv);
        end
    endtask

    task automatic put(input int off, input logic [31:0] w);
        dmem[off/4] = w;
        rmem[off/4] = w;
    endtask

    task automatic wipe();
        for (int i = 0; i < 1024; i++) begin dmem[i] = '0; rmem[i] = '0; end
    endtask

    // Behavioural chain search over the reference image.
    task automatic mwalk(input int key, output int off, output int prev,
                         output bit e, output int reads, output logic [31:0] h);
        int cur = 256;
        int prv = 0;
        int nx;
        off = 0; prev = 0; e = 0; reads = 0; h = '0;
        forever begin
            h = rmem[cur/4];
            reads++;
            if (reads == 1 && h == 0) return;
            if (int'(h[15:0]) == key) begin off = cur; prev = prv; return; end
            nx = int'(h[31:20]);
            if (nx == 0) begin prev = cur; return; end
            if (nx < 256 || nx > 4088 || (nx % 4) != 0) begin e = 1; return; end
            if (reads == 1024) begin e = 1; return; end
            prv = cur; cur = nx;
        end
    endtask

    task automatic run(input bit app, input int id, input int ver, input int off,
                       input int size, input bit poke, input string req);
        int eo = 0, ep = 0, er = 0, ecyc = 0, r = 0, o = 0, p = 0;
        int cyc = 0, n = 0, mism = 0;
        bit e;
        logic [31:0] h;
        if (!app) begin
            mwalk(id, o, p, e, r, h);
            eo = o; ep = p; er = int'(e); ecyc = 2 * r;
        end else if (size < 8 || off < 256 || (off % 4) != 0 || off + size >= 4096) begin
            er = 1; ecyc = 0;
        end else if (off == 256) begin
            h = rmem[64];
            rmem[64] = {h[31:20], 4'(ver), 16'(id)};
            eo = 256; ep = 0; ecyc = 3;
        end else begin
            mwalk(0, o, p, e, r, h);
            if (e || o != 0 || p == 0) begin
                er = 1; ecyc = 2 * r;
            end else begin
                rmem[p/4] = {12'(off), h[19:0]};
                rmem[off/4] = {12'h000, 4'(ver), 16'(id)};
                eo = off; ep = p; ecyc = 2 * r + 2;
            end
        end
        @(negedge clk);
        start = 1'b1; cmd_append = app; cmd_id = 16'(id); cmd_ver = 4'(ver);
        cmd_off = 12'(off); cmd_size = 13'(size);
        @(negedge clk);
        start = 1'b0;
        while (!done && n < 5000) begin
            if (busy) cyc++;
            if (poke && n == 0) begin
                start = 1'b1; cmd_append = 1'b0; cmd_id = 16'h0077;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        chk(done == 1'b1, req, "done seen", int'(done), 1);
        chk(cyc == ecyc, {req, " R11"}, "busy cycles", cyc, ecyc);
        chk(int'(err) == er, req, "err", int'(err), er);
        if (er == 0) begin
            chk(int'(res_off) == eo, req, "res_off", int'(res_off), eo);
            chk(int'(res_prev) == ep, req, "res_prev", int'(res_prev), ep);
        end
        for (int i = 0; i < 1024; i++) if (dmem[i] !== rmem[i]) mism++;
        chk(mism == 0, req, "memory image words differing", mism, 0);
        @(negedge clk);
        chk(done == 1'b0, "R11", "done pulse width", int'(done), 0);
    endtask

    initial begin
        wipe();
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(busy == 0 && done == 0 && err == 0, "R12", "status after reset",
            int'({busy, done, err}), 0);
        chk(mem_rd_en == 0 && mem_wr_en == 0, "R12", "memory strobes after reset",
            int'({mem_rd_en, mem_wr_en}), 0);
        rst_n = 1'b1;
        run(0, 16'h0001, 0, 0, 0, 0, "R2 empty search");
        run(0, 16'h0000, 0, 0, 0, 0, "R2 empty tail search");
        run(1, 16'h0001, 1, 12'h200, 8, 0, "R10 append to empty chain");
        run(1, 16'h0001, 1, 12'h100, 16, 0, "R7 head append on empty");
        run(1, 16'h0002, 1, 12'h200, 12'h40, 0, "R8 append after head");
        run(1, 16'h0003, 2, 12'h300, 12'h40, 1, "R8 R11 append with ignored start");
        run(0, 16'h0003, 0, 0, 0, 0, "R1 R3 match at tail");
        run(0, 16'h0002, 0, 0, 0, 1, "R3 R11 match in middle, start ignored");
        run(0, 16'h0001, 0, 0, 0, 0, "R3 match at head");
        run(0, 16'h0055, 0, 0, 0, 0, "R4 no match");
        run(0, 16'h0000, 0, 0, 0, 0, "R4 tail search");
        run(1, 16'h0007, 3, 12'h100, 8, 0, "R7 head append keeps link");
        run(0, 16'h0002, 0, 0, 0, 0, "R7 chain intact after head append");
        run(1, 16'h0008, 1, 12'h0FC, 8, 0, "R9 offset below base");
        run(1, 16'h0008, 1, 12'h400, 4, 0, "R9 size below 8");
        run(1, 16'h0008, 1, 12'h402, 8, 0, "R9 misaligned offset");
        run(1, 16'h0008, 1, 12'hFC0, 12'h40, 0, "R9 region reaches 0x1000");
        run(1, 16'h0008, 1, 12'hFC0, 12'h3C, 0, "R9 R8 region ends at 0xFFC");
        // Corrupt the tail link of the chain in several ways.
        put(12'hFC0, {12'h302, 4'h1, 16'h0008});
        run(0, 16'h0099, 0, 0, 0, 0, "R5 misaligned link");
        put(12'hFC0, {12'h080, 4'h1, 16'h0008});
        run(0, 16'h0099, 0, 0, 0, 0, "R5 link below base");
        put(12'hFC0, {12'hFFC, 4'h1, 16'h0008});
        run(0, 16'h0099, 0, 0, 0, 0, "R5 link above 0xFF8");
        put(12'hFC0, {12'hFF8, 4'h1, 16'h0008});
        put(12'hFF8, {12'h000, 4'h1, 16'h0009});
        run(0, 16'h0009, 0, 0, 0, 0, "R5 link at 0xFF8 followed");
        put(12'hFF8, {12'h000, 4'h1, 16'h0000});
        run(1, 16'h000A, 1, 12'h500, 8, 0, "R10 tail search meets ID 0");
        // Two-node cycle.
        wipe();
        put(12'h100, {12'h200, 4'h1, 16'h0001});
        put(12'h200, {12'h100, 4'h1, 16'h0002});
        run(0, 16'h0005, 0, 0, 0, 0, "R6 cyclic chain");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule